// File: doc/BRIEF.md
# Edge-Selectable Timer Capture Unit

This block watches a set of external capture inputs (four by default) and, when a chosen transition appears on one of them, records the value of a free-running timer counter in that input's own capture register. The counter is not kept in the block. Its value arrives on an input bus from the timer that owns it. Each input first passes through a synchronizer chain (two flops by default) and then through an edge detector. A per-channel control field chooses whether rising transitions, falling transitions, both or neither cause a capture. A separate bit in the same field chooses whether a capture also raises a sticky interrupt flag.

A channel that the surrounding timer uses as its counting clock is left with its whole control field at zero. That channel then never captures and never flags, and the other channels keep working normally. Software writes the whole control word in one cycle. It reads the capture registers and flags directly from the output buses, and clears flags by writing ones to them. No data stream crosses this block's boundary, so every pin is a plain control or status signal and none has a valid/ready handshake.

Top module: `tcap_unit`

## Requirements
- R1: After reset, the control word, every capture register, every flag and `irq` are all 0.
- R2: Control bit 3n enables capture on a 0-to-1 transition of `cap_in[n]`. The capture register of channel n then takes the value `count_in` holds at the third rising clock edge after the input changes, and it shows that value right after that edge.
- R3: Control bit 3n+1 enables capture on a 1-to-0 transition of `cap_in[n]`, with the same latency as R2.
- R4: With bits 3n and 3n+1 both set, every transition of `cap_in[n]` in either direction causes a capture.
- R5: A capture register keeps its value whenever its channel's transition has no enable. A channel whose three control bits are all 000 never captures and never flags, while the other channels capture as programmed.
- R6: Control bit 3n+2 makes a capture on channel n set `flags[n]` at the same edge as the capture. When that bit is 0 the capture still happens but the flag stays unchanged.
- R7: A flag is sticky. It is cleared only by a cycle with `flag_clr` high and a 1 in the matching bit of `flag_clr_mask`. A 0 in the mask leaves the flag as it is. If a set and a clear reach the same flag in the same cycle, the set wins.
- R8: `irq` is high exactly when at least one flag is set.
- R9: Channels are independent. A transition on one input never changes another channel's capture register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Registers clear while it is low. |
| count_in | input | CW (32) | Current timer counter value |
| cap_in | input | NCH (4) | Asynchronous capture inputs, one bit per channel |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 3*NCH (12) | New control word. Per channel: rise, fall, interrupt enable. |
| ctl_q | output | 3*NCH (12) | Current control word |
| flag_clr | input | 1 | Clear strobe for the interrupt flags |
| flag_clr_mask | input | NCH (4) | Flags to clear. A 1 clears that flag. |
| cap_vals | output | NCH*CW (128) | Capture registers. Channel n is in bits n*CW +: CW. |
| flags | output | NCH (4) | Sticky capture interrupt flags |
| irq | output | 1 | OR of all flags |

## Verification
The hardest case to reach from the ports is a capture that lands on a flag in the very cycle the flag is being cleared. The capture edge lies three clock edges behind the input change, so the clear has to be lined up with a synchronizer delay that the ports do not show. The stimulus changes the input on a falling clock edge, counts two rising edges, and then raises the clear so that it is sampled at the third edge, where the capture happens. Channels with both edges enabled are toggled in each direction with a different counter value each time, and a channel at 000 is toggled alongside them, so that a missed or leaked capture shows up as a wrong value.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int CH_BITS = 3;

  // Per-channel control field; LSB is rise enable.
  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } chan_ctl_t;
endpackage

// File: rtl/tcap_edge_det.sv
module tcap_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= async_in;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
  assign fall = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int CW = 32,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          async_in,
  input  chan_ctl_t     ctl,
  input  logic [CW-1:0] count_in,
  input  logic          clr,
  output logic [CW-1:0] cap_q,
  output logic          flag_q
);
  logic rise, fall, event_hit;

  tcap_edge_det #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_in(async_in), .rise(rise), .fall(fall)
  );

  assign event_hit = (rise & ctl.rise_en) | (fall & ctl.fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cap_q <= '0;
    else if (event_hit) cap_q <= count_in;
  end

  // A new event takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag_q <= 1'b0;
    else if (event_hit && ctl.irq_en)  flag_q <= 1'b1;
    else if (clr)                      flag_q <= 1'b0;
  end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW-1:0]          count_in,
  input  logic [NCH-1:0]         cap_in,
  input  logic                   ctl_wr,
  input  logic [NCH*CH_BITS-1:0] ctl_wdata,
  output logic [NCH*CH_BITS-1:0] ctl_q,
  input  logic                   flag_clr,
  input  logic [NCH-1:0]         flag_clr_mask,
  output logic [NCH*CW-1:0]      cap_vals,
  output logic [NCH-1:0]         flags,
  output logic                   irq
);
  localparam int CTLW = NCH * CH_BITS;

  logic [CTLW-1:0] ctl_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_r <= '0;
    else if (ctl_wr) ctl_r <= ctl_wdata;
  end
  assign ctl_q = ctl_r;

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_ch
      tcap_channel #(.CW(CW), .STAGES(SYNC_STAGES)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(cap_in[n]),
        .ctl     (chan_ctl_t'(ctl_r[n*CH_BITS +: CH_BITS])),
        .count_in(count_in),
        .clr     (flag_clr & flag_clr_mask[n]),
        .cap_q   (cap_vals[n*CW +: CW]),
        .flag_q  (flags[n])
      );
    end
  endgenerate

  assign irq = |flags;
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk #(
  parameter int NCH = 4,
  parameter int CW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*3-1:0]  ctl_q,
  input logic              flag_clr,
  input logic [NCH-1:0]    flag_clr_mask,
  input logic [NCH*CW-1:0] cap_vals,
  input logic [NCH-1:0]    flags,
  input logic              irq
);
  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_a
      // R5: no edge enabled -> capture register holds
      a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[3*n] && !ctl_q[3*n+1]) |=> $stable(cap_vals[n*CW +: CW]));
      // R6: a clear flag stays clear without interrupt enable
      a_r6_no_flag_without_ie: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[3*n+2] && !flags[n]) |=> !flags[n]);
      // R7: flag sticky unless cleared
      a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[n] && !(flag_clr && flag_clr_mask[n])) |=> flags[n]);
      // R6: rising flag implies interrupt enable was set
      a_r6_rise_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[n]) |-> $past(ctl_q[3*n+2]));
    end
  endgenerate

  // R8: interrupt line tracks flags
  a_r8_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $countones(flags) > 0);
endmodule

bind tcap_unit tcap_unit_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .flag_clr(flag_clr),
  .flag_clr_mask(flag_clr_mask), .cap_vals(cap_vals), .flags(flags), .irq(irq)
);

// File: tb/tb_tcap_unit.sv
module tb_tcap_unit;
  localparam int NCH = 4;
  localparam int CW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CW-1:0]     count_in = '0;
  logic [NCH-1:0]    cap_in = '0;
  logic              ctl_wr = 1'b0;
  logic [NCH*3-1:0]  ctl_wdata = '0;
  logic [NCH*3-1:0]  ctl_q;
  logic              flag_clr = 1'b0;
  logic [NCH-1:0]    flag_clr_mask = '0;
  logic [NCH*CW-1:0] cap_vals;
  logic [NCH-1:0]    flags;
  logic              irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcap_unit #(.NCH(NCH), .CW(CW)) dut (.*);

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] capv(input int ch);
    return cap_vals[ch*CW +: CW];
  endfunction

  task automatic write_ctl(input logic [NCH*3-1:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  // Drive input at negedge; capture occurs at 3rd posedge; return at following negedge.
  task automatic drive_in(input int ch, input logic lvl, input logic [CW-1:0] cnt);
    @(negedge clk); cap_in[ch] = lvl; count_in = cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flags(input logic [NCH-1:0] m);
    @(negedge clk); flag_clr = 1'b1; flag_clr_mask = m;
    @(negedge clk); flag_clr = 1'b0; flag_clr_mask = '0;
  endtask

  task automatic t_reset;
    check("R1 ctl", CW'(ctl_q), '0);
    for (int c = 0; c < NCH; c++) check("R1 cap", capv(c), '0);
    check("R1 flags", CW'(flags), '0);
    check("R1 irq", CW'(irq), '0);
  endtask

  task automatic t_rise;
    write_ctl(12'h001);               // ch0 rise only
    drive_in(0, 1'b1, 32'h0000_1111);
    check("R2 rise capture", capv(0), 32'h0000_1111);
    drive_in(0, 1'b0, 32'h0000_2222);
    check("R2 fall ignored", capv(0), 32'h0000_1111);
  endtask

  task automatic t_fall;
    write_ctl(12'h010);               // ch1 fall only (bit 4)
    drive_in(1, 1'b1, 32'h0000_3333);
    check("R3 rise ignored", capv(1), '0);
    drive_in(1, 1'b0, 32'h0000_4444);
    check("R3 fall capture", capv(1), 32'h0000_4444);
  endtask

  task automatic t_both_and_off;
    write_ctl(12'h0C0);               // ch2 rise+fall (bits 6,7), ch3 000
    drive_in(2, 1'b1, 32'hAAAA_0001);
    check("R4 both rise", capv(2), 32'hAAAA_0001);
    drive_in(2, 1'b0, 32'hAAAA_0002);
    check("R4 both fall", capv(2), 32'hAAAA_0002);
    drive_in(3, 1'b1, 32'hBBBB_0001);
    check("R5 off channel rise", capv(3), '0);
    drive_in(3, 1'b0, 32'hBBBB_0002);
    check("R5 off channel fall", capv(3), '0);
    check("R5 off channel flag", CW'(flags[3]), '0);
    check("R9 ch0 untouched", capv(0), 32'h0000_1111);
    check("R9 ch1 untouched", capv(1), 32'h0000_4444);
  endtask

  task automatic t_irq;
    check("R6 no flag without ie", CW'(flags), '0);
    write_ctl(12'h005);               // ch0 rise + irq (bits 0,2)
    drive_in(0, 1'b1, 32'h5555_0000);
    check("R6 capture with ie", capv(0), 32'h5555_0000);
    check("R6 flag set", CW'(flags), 32'h1);
    check("R8 irq high", CW'(irq), 32'h1);
    clear_flags(4'b1110);
    check("R7 mask zero keeps flag", CW'(flags), 32'h1);
    clear_flags(4'b0001);
    check("R7 clear by one", CW'(flags), '0);
    check("R8 irq low", CW'(irq), '0);
  endtask

  task automatic t_set_beats_clear;
    // ch1 rise + fall + irq (bits 3,4,5); input currently 0
    write_ctl(12'h038);
    @(negedge clk); cap_in[1] = 1'b1; count_in = 32'h7777_0000;
    repeat (2) @(posedge clk);
    @(negedge clk); flag_clr = 1'b1; flag_clr_mask = 4'b0010;
    @(posedge clk);
    @(negedge clk); flag_clr = 1'b0; flag_clr_mask = '0;
    check("R7 set wins over clear", CW'(flags), 32'h2);
    check("R7 capture value", capv(1), 32'h7777_0000);
    check("R9 ch0 flag unaffected", CW'(flags[0]), '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both_and_off();
    t_irq();
    t_set_beats_clear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule